// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating analogue-to-digital converter that works in two ramps. An accepted start latches a channel number for the analogue input multiplexer. It then runs a short capacitor preparation phase, which either shorts the capacitor or precharges it, as chosen with the start. After that it holds the input transconductor on for a fixed window of 2^RES_W clock cycles. Last, it switches to a constant-current sink and counts clock cycles until the comparator reports that the capacitor voltage has crossed its threshold. The length of that second ramp is the conversion result.

The comparator output is asynchronous. It passes through a synchroniser of SYNC_STAGES flops, and the count is corrected for that latency before it is stored. The result counter is one bit wider than the resolution. When the comparator has not been seen by the time the counter reaches its top value, the conversion ends with the overflow flag set and the result saturated at that top value. The result and the valid flag are written on the same edge. Both stay as they are until the next accepted start.

Top module: `dual_slope_seq`

## Requirements
- R1: While rst_ni is low, every phase control output, valid_o, overflow_o, result_o and ch_sel_o are zero.
- R2: start_i is accepted only when the sequencer is idle or done and channel_i is below NUM_CH (36). On the edge that accepts it, channel_i is latched into ch_sel_o, valid_o and overflow_o are cleared, and the preparation phase begins.
- R3: The preparation phase lasts exactly PREP_CYC (16) cycles. It drives cap_reset_o when prep_mode_i was 0 at the accepted start, and precharge_o when prep_mode_i was 1.
- R4: charge_o is high for exactly 2^RES_W (4096) consecutive cycles, directly after the preparation phase.
- R5: discharge_o rises on the cycle after charge_o falls. At most one of cap_reset_o, precharge_o, charge_o and discharge_o is high in any cycle.
- R6: If cmp_i goes high after N complete discharge cycles and N <= 2^(RES_W+1)-3 (8189), the conversion ends after N+3 discharge cycles with result_o = N and overflow_o = 0.
- R7: If no comparator trip has reached the counter by the cycle in which the counter holds 2^(RES_W+1)-1, the conversion ends after 2^(RES_W+1) (8192) discharge cycles with overflow_o = 1 and result_o = 8191.
- R8: result_o, overflow_o and valid_o are updated on the same edge at the end of the discharge phase. valid_o and the stored result then stay unchanged until the next accepted start.
- R9: A start_i pulse that arrives during a conversion is ignored. ch_sel_o, the phase lengths and the result are unaffected.
- R10: A start_i pulse whose channel_i is 36 or more is ignored. No phase starts, and valid_o and result_o keep their values.
- R11: If cmp_i is already high when the discharge phase begins, the conversion ends after one discharge cycle with result_o = 0 and overflow_o = 0. The latency correction never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start a conversion (one-cycle pulse) |
| channel_i | input | 6 | Channel number to convert |
| prep_mode_i | input | 1 | Preparation mode: 0 shorts the capacitor, 1 precharges it |
| cmp_i | input | 1 | Asynchronous comparator output, high once the threshold is crossed |
| ch_sel_o | output | 6 | Channel select for the analogue input multiplexer |
| cap_reset_o | output | 1 | Capacitor short control |
| precharge_o | output | 1 | Capacitor precharge control |
| charge_o | output | 1 | Transconductor enable for the integration window |
| discharge_o | output | 1 | Constant-current sink enable |
| result_o | output | 13 | Corrected length of the second ramp |
| valid_o | output | 1 | result_o holds a finished conversion |
| overflow_o | output | 1 | The last conversion saturated |

## Verification
The assertions assume that cmp_i stays low during the integration window unless the case under test wants a trip that is already present. They also assume that cmp_i, once high, stays high until the result is valid, as a real comparator does on a ramp that moves in one direction. The bench models the comparator this way. It raises cmp_i away from the clock edge, either after a chosen number of observed discharge cycles or before the discharge begins, and it lowers cmp_i only after valid_o. It also drives start_i and channel_i away from the edge, including a start while the block is busy and a start with a channel number out of range.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PREP   = 3'd1,
    ST_CHARGE = 3'd2,
    ST_DISCH  = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  // Counts down and parks at zero; a phase ends on the edge that sees zero.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_ramp.sv
module adc_seq_ramp #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = &cnt_q;
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int NUM_CH      = 36,
  parameter int PREP_CYC    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int CNT_W      = RES_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CH_W-1:0]  channel_i,
  input  logic             prep_mode_i,
  input  logic             cmp_i,
  output logic [CH_W-1:0]  ch_sel_o,
  output logic             cap_reset_o,
  output logic             precharge_o,
  output logic             charge_o,
  output logic             discharge_o,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             overflow_o
);
  localparam int CHG_CYC  = 1 << RES_W;
  localparam int PREP_W   = $clog2(PREP_CYC);
  localparam int TMR_W    = (RES_W > PREP_W) ? RES_W : PREP_W;
  localparam logic [TMR_W-1:0] PREP_LOAD = TMR_W'(PREP_CYC - 1);
  localparam logic [TMR_W-1:0] CHG_LOAD  = TMR_W'(CHG_CYC - 1);
  localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(NUM_CH - 1);
  localparam logic [CNT_W-1:0] LAT       = CNT_W'(SYNC_STAGES);

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             ramp_clr, ramp_en, ramp_max;
  logic [CNT_W-1:0] ramp_cnt, ramp_comp;
  logic             cmp_s, start_ok, finish;
  logic             mode_q;
  logic [CH_W-1:0]  ch_q;
  logic [CNT_W-1:0] res_q;
  logic             valid_q, ovf_q;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  adc_seq_timer #(.W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  adc_seq_ramp #(.W(CNT_W)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ramp_clr),
    .en_i    (ramp_en),
    .cnt_o   (ramp_cnt),
    .at_max_o(ramp_max)
  );

  assign start_ok = start_i && (channel_i <= CH_LAST) &&
                    ((state_q == ST_IDLE) || (state_q == ST_DONE));

  // Remove synchroniser latency; clamp when the trip predates the ramp.
  assign ramp_comp = (ramp_cnt >= LAT) ? (ramp_cnt - LAT) : '0;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ramp_clr = 1'b0;
    ramp_en  = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_ok) begin
          state_d  = ST_PREP;
          tmr_load = 1'b1;
          tmr_val  = PREP_LOAD;
        end
      end
      ST_PREP: begin
        if (tmr_zero) begin
          state_d  = ST_CHARGE;
          tmr_load = 1'b1;
          tmr_val  = CHG_LOAD;
        end
      end
      ST_CHARGE: begin
        if (tmr_zero) begin
          state_d  = ST_DISCH;
          ramp_clr = 1'b1;
        end
      end
      ST_DISCH: begin
        // A trip seen on the terminal cycle wins over overflow.
        if (cmp_s || ramp_max) begin
          state_d = ST_DONE;
          finish  = 1'b1;
        end else begin
          ramp_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      mode_q  <= 1'b0;
      res_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        ch_q    <= channel_i;
        mode_q  <= prep_mode_i;
        valid_q <= 1'b0;
        ovf_q   <= 1'b0;
      end else if (finish) begin
        valid_q <= 1'b1;
        ovf_q   <= ~cmp_s;
        res_q   <= cmp_s ? ramp_comp : '1;
      end
    end
  end

  assign ch_sel_o    = ch_q;
  assign cap_reset_o = (state_q == ST_PREP) && !mode_q;
  assign precharge_o = (state_q == ST_PREP) &&  mode_q;
  assign charge_o    = (state_q == ST_CHARGE);
  assign discharge_o = (state_q == ST_DISCH);
  assign result_o    = res_q;
  assign valid_o     = valid_q;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int RES_W    = 12,
  parameter int PREP_CYC = 16,
  parameter int CH_W     = 6,
  parameter int CNT_W    = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CH_W-1:0]  ch_sel_o,
  input logic             cap_reset_o,
  input logic             precharge_o,
  input logic             charge_o,
  input logic             discharge_o,
  input logic [CNT_W-1:0] result_o,
  input logic             valid_o,
  input logic             overflow_o
);
  localparam int CHG_CYC = 1 << RES_W;

  int chg_run, prep_run;
  logic prep_on;
  assign prep_on = cap_reset_o || precharge_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_run  <= 0;
      prep_run <= 0;
    end else begin
      chg_run  <= charge_o ? chg_run + 1 : 0;
      prep_run <= prep_on  ? prep_run + 1 : 0;
    end
  end

  AST_PREP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prep_on) |-> (prep_run == PREP_CYC && charge_o));  // R3
  AST_CHARGE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(charge_o) |-> (chg_run == CHG_CYC));  // R4
  AST_DISCH_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(charge_o) |-> discharge_o);  // R5
  AST_ONE_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cap_reset_o, precharge_o, charge_o, discharge_o}));  // R5
  AST_OVF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (valid_o && (&result_o)));  // R7
  AST_VALID_AFTER_DISCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(discharge_o));  // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> ($stable(result_o) && $stable(overflow_o)));  // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(prep_on || charge_o || discharge_o));  // R8
  AST_CH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((charge_o || discharge_o) && $past(charge_o || discharge_o)) |-> $stable(ch_sel_o));  // R9
endmodule

bind dual_slope_seq dual_slope_seq_chk #(
  .RES_W   (RES_W),
  .PREP_CYC(PREP_CYC),
  .CH_W    (CH_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ch_sel_o   (ch_sel_o),
  .cap_reset_o(cap_reset_o),
  .precharge_o(precharge_o),
  .charge_o   (charge_o),
  .discharge_o(discharge_o),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .overflow_o (overflow_o)
);

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PREP_CYC   = 16;
  localparam int CHG_CYC    = 4096;
  localparam int CNT_MAX    = 8191;
  localparam int NO_TRIP    = -1;
  localparam int EARLY_TRIP = -2;

  localparam int NVEC = 6;
  localparam int VEC_CH   [NVEC] = '{0, 3, 35, 17, 31, 8};
  localparam int VEC_MODE [NVEC] = '{0, 1, 0, 1, 0, 1};
  localparam int VEC_TRIP [NVEC] = '{0, 1, 100, 4095, 8189, 8190};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  channel_i = '0;
  logic        prep_mode_i = 1'b0;
  logic        cmp_i = 1'b0;
  logic [5:0]  ch_sel_o;
  logic        cap_reset_o, precharge_o, charge_o, discharge_o;
  logic [12:0] result_o;
  logic        valid_o, overflow_o;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_slope_seq uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .channel_i  (channel_i),
    .prep_mode_i(prep_mode_i),
    .cmp_i      (cmp_i),
    .ch_sel_o   (ch_sel_o),
    .cap_reset_o(cap_reset_o),
    .precharge_o(precharge_o),
    .charge_o   (charge_o),
    .discharge_o(discharge_o),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .overflow_o (overflow_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  // trip >= 0: raise cmp_i after trip discharge cycles; NO_TRIP / EARLY_TRIP special.
  task automatic run_conv(input int ch, input int mode, input int trip, input bit poke);
    int n_prep = 0, n_chg = 0, n_dis = 0, bad_mode = 0, res_moved = 0;
    int exp_res, exp_dis, exp_ovf, prev_res;
    if (trip == EARLY_TRIP) begin
      exp_res = 0; exp_ovf = 0; exp_dis = 1;
    end else if (trip >= 0 && trip <= CNT_MAX - 2) begin
      exp_res = trip; exp_ovf = 0; exp_dis = trip + 3;
    end else begin
      exp_res = CNT_MAX; exp_ovf = 1; exp_dis = CNT_MAX + 1;
    end
    prev_res = int'(result_o);
    @(negedge clk_i);
    start_i = 1'b1; channel_i = 6'(ch); prep_mode_i = mode[0];
    if (trip == EARLY_TRIP) cmp_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(valid_o == 1'b0, "R2", "valid cleared on start", int'(valid_o), 0);
    chk(overflow_o == 1'b0, "R2", "overflow cleared on start", int'(overflow_o), 0);
    chk(ch_sel_o == 6'(ch), "R2", "channel latched", int'(ch_sel_o), ch);
    while (!valid_o) begin
      if (int'(result_o) != prev_res) res_moved++;
      if (cap_reset_o || precharge_o) begin
        n_prep++;
        if ((mode != 0) ? cap_reset_o : precharge_o) bad_mode++;
      end
      if (charge_o) begin
        n_chg++;
        if (poke && n_chg == 100) begin
          start_i = 1'b1; channel_i = 6'(ch ^ 1); prep_mode_i = ~mode[0];
        end else begin
          start_i = 1'b0;
        end
      end
      if (discharge_o) begin
        n_dis++;
        if (trip >= 0 && n_dis == trip + 1) cmp_i = 1'b1;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(n_prep == PREP_CYC, "R3", "prep length", n_prep, PREP_CYC);
    chk(bad_mode == 0, "R3", "prep control matches mode", bad_mode, 0);
    chk(n_chg == CHG_CYC, "R4", "charge length", n_chg, CHG_CYC);
    chk(n_dis == exp_dis, (exp_ovf != 0) ? "R7" : "R6", "discharge length", n_dis, exp_dis);
    chk(int'(result_o) == exp_res, (exp_ovf != 0) ? "R7" : "R6", "result", int'(result_o), exp_res);
    chk(int'(overflow_o) == exp_ovf, (exp_ovf != 0) ? "R7" : "R6", "overflow", int'(overflow_o), exp_ovf);
    chk(res_moved == 0, "R8", "result held until valid", res_moved, 0);
    chk(ch_sel_o == 6'(ch), "R9", "channel unchanged to end", int'(ch_sel_o), ch);
    cmp_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int held_res;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk({cap_reset_o, precharge_o, charge_o, discharge_o} == 4'b0, "R1", "controls in reset",
        int'({cap_reset_o, precharge_o, charge_o, discharge_o}), 0);
    chk(valid_o == 1'b0 && overflow_o == 1'b0, "R1", "flags in reset",
        int'({valid_o, overflow_o}), 0);
    chk(result_o == '0 && ch_sel_o == '0, "R1", "result and channel in reset",
        int'(result_o) + int'(ch_sel_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) run_conv(VEC_CH[i], VEC_MODE[i], VEC_TRIP[i], 1'b0);

    // R8: valid and result hold while idle
    held_res = int'(result_o);
    repeat (20) @(negedge clk_i);
    chk(valid_o == 1'b1, "R8", "valid held while idle", int'(valid_o), 1);
    chk(int'(result_o) == held_res, "R8", "result held while idle", int'(result_o), held_res);

    // R10: out-of-range channel start is ignored
    start_i = 1'b1; channel_i = 6'd36;
    @(negedge clk_i);
    start_i = 1'b0; channel_i = 6'd63;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) begin
      @(negedge clk_i);
      if (cap_reset_o || precharge_o || charge_o || !valid_o) begin
        chk(1'b0, "R10", "no phase after bad channel", 1, 0);
        break;
      end
    end
    chk(int'(result_o) == held_res, "R10", "result kept", int'(result_o), held_res);
    chk(ch_sel_o == 6'd8, "R10", "channel kept", int'(ch_sel_o), 8);

    // R9: start while busy ignored
    run_conv(12, 0, 50, 1'b1);
    // R11: comparator already high
    run_conv(20, 1, EARLY_TRIP, 1'b0);
    // R7: comparator never trips
    run_conv(34, 0, NO_TRIP, 1'b0);
    // after overflow a normal conversion clears the flag
    run_conv(1, 1, 7, 1'b0);

    summary();
  end
endmodule